// File: doc/BRIEF.md
# Multi-Source Chip Reset Sequencer

This block merges every reset request of a small controller into one synchronous chip reset. The requests are the power-on pulse, a brown-out detect, an external active-low reset pin, a watchdog timeout, a software reset command and the two stack fault flags. After a power-on or brown-out event, reset is held until two start-up delays finish in turn. The first counts ticks of a slow clock. The second counts ticks of the main oscillator. Each delay can be switched off.

Every source that causes a reset leaves a sticky flag in a cause register, which software clears with write-one-to-clear strobes. Two status flags, timeout and power-down, tell a watchdog reset, a watchdog wake-up from sleep and a supply event apart. A watchdog timeout during sleep is a wake-up, not a reset. The block has no streaming data path, so all pins are plain control and status levels.

Top module: `chip_reset_seq`

## Requirements
- R1: While bor_i, sw_rst_i, stk_ovf_i, stk_unf_i, an accepted pin request or a watchdog timeout with sleep_i low is active at a clock edge, chip_rst_o is high after that edge.
- R2: While por_i is high, chip_rst_o is 1, cause_o is 7'b0000001, to_n_o and pd_n_o are 1 and wdt_wake_o is 0, whatever the clock does.
- R3: After por_i or bor_i falls, with both delays enabled and both tick inputs held high, chip_rst_o falls at clock edge PWR_TICKS+OST_TICKS, counting the first edge after the event as edge 1. Without lf_tick_i pulses, reset never leaves the power-up delay.
- R4: Each delay has its own enable, and a disabled delay adds no ticks. With only the start-up delay enabled, release is at edge 1+OST_TICKS. With only the power-up delay enabled, release is at edge PWR_TICKS. With neither enabled, release is at edge 1.
- R5: Only por_i and bor_i restart the delays. Once the delays have completed, any other source releases chip_rst_o at the first edge after it drops.
- R6: The pin passes two synchronizing flops. It is accepted only after it is seen low for FILT_LEN consecutive clocks, so a shorter low pulse causes no reset and sets no cause bit.
- R7: With cfg_pin_en_i low, the pin causes no reset and sets no cause bit, however long it is held low.
- R8: Each source sets its own sticky cause bit, which stays set until cleared: bit 0 power-on, bit 1 brown-out, bit 2 pin, bit 3 watchdog reset, bit 4 software, bit 5 stack overflow, bit 6 stack underflow.
- R9: A high bit of cause_clr_i clears the matching cause bit at the next edge and leaves the other bits alone. If a source sets a bit in the same cycle that its clear strobe is high, the set wins.
- R10: A watchdog timeout while sleep_i is high causes no reset and sets no cause bit. It pulses wdt_wake_o for one cycle and sets to_n_o=0 and pd_n_o=0.
- R11: A brown-out sets to_n_o=1 and pd_n_o=1. A watchdog reset sets to_n_o=0 and pd_n_o=1. A rising sleep_i sets to_n_o=1 and pd_n_o=0. Pin, software and stack resets leave both status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bor_i | input | 1 | Brown-out detect, active high |
| mclr_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_to_i | input | 1 | Watchdog timeout |
| sleep_i | input | 1 | Core is in sleep |
| sw_rst_i | input | 1 | Software reset command |
| stk_ovf_i | input | 1 | Stack overflow flag |
| stk_unf_i | input | 1 | Stack underflow flag |
| lf_tick_i | input | 1 | Low-frequency tick enable |
| osc_tick_i | input | 1 | Main-oscillator tick enable |
| cfg_pwrt_en_i | input | 1 | Power-up delay enable |
| cfg_ost_en_i | input | 1 | Start-up delay enable |
| cfg_pin_en_i | input | 1 | Reset pin enable |
| cause_clr_i | input | 7 | Write-one-to-clear strobes for cause bits |
| chip_rst_o | output | 1 | Synchronous chip reset, active high |
| cause_o | output | 7 | Sticky reset-cause flags |
| to_n_o | output | 1 | Timeout status, low after a watchdog event |
| pd_n_o | output | 1 | Power-down status, low after sleep entry or wake |
| wdt_wake_o | output | 1 | One-cycle pulse on a watchdog wake-up from sleep |

## Verification
Two functions can meet in one cycle: a source setting its cause bit, and software clearing that same bit. The bench raises the software reset command in the same cycle as the clear strobe for the software bit. It then expects the bit to read as set, while a clear of another bit in that cycle still takes effect. A second overlap is a watchdog timeout that lands in the cycle after sleep entry. The bench judges that case by the status pair and by the absence of a reset.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int unsigned NSRC = 7;

  localparam int unsigned CS_POR = 0;
  localparam int unsigned CS_BOR = 1;
  localparam int unsigned CS_PIN = 2;
  localparam int unsigned CS_WDT = 3;
  localparam int unsigned CS_SW  = 4;
  localparam int unsigned CS_OVF = 5;
  localparam int unsigned CS_UNF = 6;

  typedef enum logic [1:0] {
    PH_PWRUP = 2'd0,
    PH_OSCST = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;
endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_n_i,
  input  logic en_i,
  output logic req_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CMAX = CW'(FILT_LEN);

  logic          s1_q, s2_q;
  logic [CW-1:0] run_q;

  // two-stage synchronizer, released level is high
  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= pin_n_i;
      s2_q <= s1_q;
    end
  end

  // consecutive-low counter, saturating
  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)                run_q <= '0;
    else if (!en_i || s2_q)   run_q <= '0;
    else if (run_q != CMAX)   run_q <= run_q + 1'b1;
  end

  assign req_o = en_i && (run_q == CMAX);
endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk,
  input  logic por_i,
  input  logic restart_i,
  input  logic active_i,
  input  logic tick_i,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT);
  localparam logic [CW-1:0] PEN  = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          step;

  assign step = active_i && en_i && tick_i && (cnt_q != LAST);

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)          cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step)      cnt_q <= cnt_q + 1'b1;
  end

  // finished when disabled, already full, or the final tick arrives now
  assign done_o = !en_i || (cnt_q == LAST) || (step && (cnt_q == PEN));
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic            clk,
  input  logic            por_i,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] cause_o
);
  logic [NSRC-1:0] cause_q;
  localparam logic [NSRC-1:0] POR_VAL = NSRC'(1) << CS_POR;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) cause_q <= POR_VAL;
    else       cause_q <= (cause_q & ~clr_i) | set_i;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status (
  input  logic clk,
  input  logic por_i,
  input  logic bor_i,
  input  logic wdt_rst_i,
  input  logic wdt_wake_i,
  input  logic sleep_i,
  output logic to_n_o,
  output logic pd_n_o,
  output logic wake_o
);
  logic sleep_q, to_n_q, pd_n_q, wake_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      sleep_q <= 1'b0;
      to_n_q  <= 1'b1;
      pd_n_q  <= 1'b1;
      wake_q  <= 1'b0;
    end else begin
      sleep_q <= sleep_i;
      wake_q  <= wdt_wake_i && !bor_i;
      if (bor_i) begin
        to_n_q <= 1'b1;
        pd_n_q <= 1'b1;
      end else if (wdt_rst_i) begin
        to_n_q <= 1'b0;
        pd_n_q <= 1'b1;
      end else if (wdt_wake_i) begin
        to_n_q <= 1'b0;
        pd_n_q <= 1'b0;
      end else if (sleep_i && !sleep_q) begin
        to_n_q <= 1'b1;
        pd_n_q <= 1'b0;
      end
    end
  end

  assign to_n_o = to_n_q;
  assign pd_n_o = pd_n_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/chip_reset_seq.sv
module chip_reset_seq
  import rstseq_pkg::*;
#(
  parameter int unsigned PWR_TICKS = 2048,
  parameter int unsigned OST_TICKS = 1024,
  parameter int unsigned FILT_LEN  = 4
) (
  input  logic            clk,
  input  logic            por_i,
  input  logic            bor_i,
  input  logic            mclr_n_i,
  input  logic            wdt_to_i,
  input  logic            sleep_i,
  input  logic            sw_rst_i,
  input  logic            stk_ovf_i,
  input  logic            stk_unf_i,
  input  logic            lf_tick_i,
  input  logic            osc_tick_i,
  input  logic            cfg_pwrt_en_i,
  input  logic            cfg_ost_en_i,
  input  logic            cfg_pin_en_i,
  input  logic [NSRC-1:0] cause_clr_i,
  output logic            chip_rst_o,
  output logic [NSRC-1:0] cause_o,
  output logic            to_n_o,
  output logic            pd_n_o,
  output logic            wdt_wake_o
);
  logic            pin_req, wdt_rst, wdt_wake, hold_src;
  logic            pwr_done, ost_done;
  logic [NSRC-1:0] src_set;
  phase_e          phase_q, phase_nxt;
  logic            rst_q;

  rstseq_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .por_i(por_i), .pin_n_i(mclr_n_i),
    .en_i(cfg_pin_en_i), .req_o(pin_req)
  );

  assign wdt_rst  = wdt_to_i && !sleep_i;
  assign wdt_wake = wdt_to_i && sleep_i;

  always_comb begin
    src_set         = '0;
    src_set[CS_BOR] = bor_i;
    src_set[CS_PIN] = pin_req;
    src_set[CS_WDT] = wdt_rst;
    src_set[CS_SW]  = sw_rst_i;
    src_set[CS_OVF] = stk_ovf_i;
    src_set[CS_UNF] = stk_unf_i;
  end

  assign hold_src = |src_set;

  rstseq_delay #(.LIMIT(PWR_TICKS)) u_pwrt (
    .clk(clk), .por_i(por_i), .restart_i(bor_i),
    .active_i(phase_q == PH_PWRUP), .tick_i(lf_tick_i),
    .en_i(cfg_pwrt_en_i), .done_o(pwr_done)
  );

  rstseq_delay #(.LIMIT(OST_TICKS)) u_ost (
    .clk(clk), .por_i(por_i), .restart_i(bor_i),
    .active_i(phase_q == PH_OSCST), .tick_i(osc_tick_i),
    .en_i(cfg_ost_en_i), .done_o(ost_done)
  );

  always_comb begin
    phase_nxt = phase_q;
    if (bor_i) begin
      phase_nxt = PH_PWRUP;
    end else begin
      unique case (phase_q)
        PH_PWRUP: if (pwr_done) phase_nxt = ost_done ? PH_RUN : PH_OSCST;
        PH_OSCST: if (ost_done) phase_nxt = PH_RUN;
        default:  phase_nxt = PH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      phase_q <= PH_PWRUP;
      rst_q   <= 1'b1;
    end else begin
      phase_q <= phase_nxt;
      rst_q   <= hold_src || (phase_nxt != PH_RUN);
    end
  end

  assign chip_rst_o = rst_q;

  rstseq_cause u_cause (
    .clk(clk), .por_i(por_i), .set_i(src_set),
    .clr_i(cause_clr_i), .cause_o(cause_o)
  );

  rstseq_status u_stat (
    .clk(clk), .por_i(por_i), .bor_i(bor_i), .wdt_rst_i(wdt_rst),
    .wdt_wake_i(wdt_wake), .sleep_i(sleep_i),
    .to_n_o(to_n_o), .pd_n_o(pd_n_o), .wake_o(wdt_wake_o)
  );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
  import rstseq_pkg::*;
(
  input logic            clk,
  input logic            por_i,
  input logic            bor_i,
  input logic            wdt_to_i,
  input logic            sleep_i,
  input logic            sw_rst_i,
  input logic            stk_ovf_i,
  input logic            stk_unf_i,
  input logic [NSRC-1:0] cause_clr_i,
  input logic            chip_rst_o,
  input logic [NSRC-1:0] cause_o,
  input logic            to_n_o,
  input logic            pd_n_o,
  input logic            wdt_wake_o
);
  logic direct_src;
  assign direct_src = bor_i || sw_rst_i || stk_ovf_i || stk_unf_i ||
                      (wdt_to_i && !sleep_i);

  // R1
  src_holds_rst_chk: assert property (@(posedge clk) disable iff (por_i)
    direct_src |=> chip_rst_o);

  // R5
  release_quiet_chk: assert property (@(posedge clk) disable iff (por_i)
    $fell(chip_rst_o) |-> $past(!direct_src));

  // R8
  sticky_cause_chk: assert property (@(posedge clk) disable iff (por_i)
    1'b1 |=> ((cause_o & $past(cause_o & ~cause_clr_i)) == $past(cause_o & ~cause_clr_i)));

  // R9
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (por_i)
    (sw_rst_i && cause_clr_i[CS_SW]) |=> cause_o[CS_SW]);

  // R10
  wake_no_rst_chk: assert property (@(posedge clk) disable iff (por_i)
    (wdt_to_i && sleep_i && !chip_rst_o && !bor_i && !sw_rst_i && !stk_ovf_i && !stk_unf_i)
      |=> (wdt_wake_o && !to_n_o && !pd_n_o));

  // R11
  bor_status_chk: assert property (@(posedge clk) disable iff (por_i)
    bor_i |=> (to_n_o && pd_n_o && cause_o[CS_BOR]));
endmodule

bind chip_reset_seq rstseq_chk u_chk (
  .clk(clk), .por_i(por_i), .bor_i(bor_i), .wdt_to_i(wdt_to_i),
  .sleep_i(sleep_i), .sw_rst_i(sw_rst_i), .stk_ovf_i(stk_ovf_i),
  .stk_unf_i(stk_unf_i), .cause_clr_i(cause_clr_i), .chip_rst_o(chip_rst_o),
  .cause_o(cause_o), .to_n_o(to_n_o), .pd_n_o(pd_n_o), .wdt_wake_o(wdt_wake_o)
);

// File: tb/tb_chip_reset_seq.sv
module tb_chip_reset_seq;
  localparam int P = 5;
  localparam int O = 7;
  localparam int F = 4;

  logic       clk = 1'b0;
  logic       por_i = 1'b1, bor_i = 1'b0, mclr_n_i = 1'b1, wdt_to_i = 1'b0;
  logic       sleep_i = 1'b0, sw_rst_i = 1'b0, stk_ovf_i = 1'b0, stk_unf_i = 1'b0;
  logic       lf_tick_i = 1'b1, osc_tick_i = 1'b1;
  logic       cfg_pwrt_en_i = 1'b1, cfg_ost_en_i = 1'b1, cfg_pin_en_i = 1'b1;
  logic [6:0] cause_clr_i = '0;
  logic       chip_rst_o, to_n_o, pd_n_o, wdt_wake_o;
  logic [6:0] cause_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  chip_reset_seq #(.PWR_TICKS(P), .OST_TICKS(O), .FILT_LEN(F)) dut (
    .clk(clk), .por_i(por_i), .bor_i(bor_i), .mclr_n_i(mclr_n_i),
    .wdt_to_i(wdt_to_i), .sleep_i(sleep_i), .sw_rst_i(sw_rst_i),
    .stk_ovf_i(stk_ovf_i), .stk_unf_i(stk_unf_i), .lf_tick_i(lf_tick_i),
    .osc_tick_i(osc_tick_i), .cfg_pwrt_en_i(cfg_pwrt_en_i),
    .cfg_ost_en_i(cfg_ost_en_i), .cfg_pin_en_i(cfg_pin_en_i),
    .cause_clr_i(cause_clr_i), .chip_rst_o(chip_rst_o), .cause_o(cause_o),
    .to_n_o(to_n_o), .pd_n_o(pd_n_o), .wdt_wake_o(wdt_wake_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // edges until chip_rst_o is low, first edge after the event = 1
  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      n++;
      if (!chip_rst_o) break;
    end
  endtask

  function automatic int release_edge(input bit pe, input bit oe);
    int r;
    r = pe ? P : 1;
    if (oe) r = r + O;
    return r;
  endfunction

  task automatic clear_all();
    cause_clr_i = 7'h7f;
    step();
    cause_clr_i = '0;
  endtask

  // count cycles with chip reset high while a source pulses for len cycles
  task automatic pulse_count(input int which, input int len, output int hi);
    hi = 0;
    for (int i = 0; i < len; i++) begin
      case (which)
        0: sw_rst_i = 1'b1;
        1: stk_ovf_i = 1'b1;
        2: stk_unf_i = 1'b1;
        3: wdt_to_i = 1'b1;
        default: mclr_n_i = 1'b0;
      endcase
      step();
      if (chip_rst_o) hi++;
    end
    sw_rst_i = 0; stk_ovf_i = 0; stk_unf_i = 0; wdt_to_i = 0; mclr_n_i = 1;
    for (int i = 0; i < F + 6; i++) begin
      step();
      if (chip_rst_o) hi++;
    end
  endtask

  initial begin
    int n, hi;
    logic [6:0] bitv;
    // R2 reset state while por is high, clock running
    step(); step();
    chk("R2 rst", chip_rst_o, 1);
    chk("R2 cause", cause_o, 7'b0000001);
    chk("R2 to_n", to_n_o, 1);
    chk("R2 pd_n", pd_n_o, 1);
    chk("R2 wake", wdt_wake_o, 0);

    // R3 R4 sweep of delay enables after power-on and after brown-out
    for (int c = 0; c < 4; c++) begin
      cfg_pwrt_en_i = c[0];
      cfg_ost_en_i  = c[1];
      por_i = 1'b1;
      step();
      por_i = 1'b0;
      measure(n);
      chk("R3 R4 por release", n, release_edge(c[0], c[1]));
      bor_i = 1'b1;
      step();
      chk("R1 bor rst", chip_rst_o, 1);
      chk("R11 bor status", {to_n_o, pd_n_o}, 2'b11);
      bor_i = 1'b0;
      measure(n);
      chk("R3 R4 bor release", n, release_edge(c[0], c[1]));
      chk("R8 cause por+bor", cause_o, 7'b0000011);
    end

    // R3 no low-frequency ticks: held in power-up delay
    cfg_pwrt_en_i = 1; cfg_ost_en_i = 1;
    lf_tick_i = 0;
    bor_i = 1; step(); bor_i = 0;
    hi = 0;
    for (int i = 0; i < 60; i++) begin step(); if (chip_rst_o) hi++; end
    chk("R3 stall", hi, 60);
    lf_tick_i = 1;
    measure(n);
    chk("R3 resume", n, P + O);
    clear_all();
    chk("R9 clear all", cause_o, 0);

    // R1 R5 R8 other sources: reset only while active, no delay restart
    for (int s = 0; s < 4; s++) begin
      pulse_count(s, 3, hi);
      chk("R1 R5 hold then release", hi, 3);
      bitv = 7'(1 << (s == 0 ? 4 : s == 1 ? 5 : s == 2 ? 6 : 3));
      chk("R8 cause bit", cause_o, bitv);
      if (s == 3) chk("R11 wdt reset status", {to_n_o, pd_n_o}, 2'b01);
      else        chk("R11 unchanged status", {to_n_o, pd_n_o}, 2'b11);
      clear_all();
    end

    // R6 pin filter sweep of pulse lengths
    for (int len = 1; len <= F + 2; len++) begin
      pulse_count(4, len, hi);
      chk("R6 pin accepted", hi > 0, len >= F);
      chk("R6 pin cause", cause_o[2], len >= F);
      chk("R6 released", chip_rst_o, 0);
      clear_all();
    end

    // R7 pin disabled
    cfg_pin_en_i = 0;
    pulse_count(4, 3 * F, hi);
    chk("R7 pin ignored rst", hi, 0);
    chk("R7 pin ignored cause", cause_o, 0);
    cfg_pin_en_i = 1;

    // R9 set and clear of one bit in the same cycle, other bit cleared
    stk_ovf_i = 1; step(); stk_ovf_i = 0; step();
    sw_rst_i = 1; cause_clr_i = 7'b0110000;
    step();
    sw_rst_i = 0; cause_clr_i = '0;
    chk("R9 set wins, other cleared", cause_o, 7'b0010000);
    step();
    cause_clr_i = 7'b0010000; step(); cause_clr_i = '0;
    chk("R9 w1c", cause_o, 0);

    // R10 R11 sleep entry and watchdog wake
    sleep_i = 1; step();
    chk("R11 sleep status", {to_n_o, pd_n_o}, 2'b10);
    wdt_to_i = 1; step(); wdt_to_i = 0;
    chk("R10 wake pulse", wdt_wake_o, 1);
    chk("R10 no rst", chip_rst_o, 0);
    chk("R10 status", {to_n_o, pd_n_o}, 2'b00);
    chk("R10 no cause", cause_o, 0);
    step();
    chk("R10 pulse one cycle", wdt_wake_o, 0);
    chk("R10 still no rst", chip_rst_o, 0);
    sleep_i = 0; step();

    // R10 wake in the cycle after sleep entry
    sleep_i = 1; step();
    wdt_to_i = 1; step(); wdt_to_i = 0;
    chk("R10 back-to-back status", {to_n_o, pd_n_o, chip_rst_o}, 3'b000);
    sleep_i = 0; step();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule